// File: doc/BRIEF.md
# Configuration Stream Header Probe

This block sits beside a configuration data path and looks at a bitstream as it passes by in 32-bit beats. Each beat is transferred when both valid and ready are high. The probe never holds the stream back: it passes the downstream ready straight back to the source. It takes in every beat and counts it. It keeps the first three words, so it can identify the image's security magic and section type. It reads an encryption flag from one fixed header word and a compression flag from a later one.

When the later flag word arrives, the probe settles the results. It computes the clock-to-data ratio code from the two flags and from the configuration width on `wide_i`. It registers all results and signals them with a one-cycle done pulse. If the stream ends before that word arrives, the probe gives a one-cycle error pulse instead and keeps its previous results. Once a stream ends with its last beat, the next accepted beat counts as word 0 of a new header.

Top module: `bs_hdr_probe`

## Requirements
- R1: `in_ready_o` equals `dn_ready_i` in every cycle. A beat counts only when `in_valid_i` and `dn_ready_i` are both high.
- R2: The encryption flag is set when bits [3:2] of word 69 are not both zero. Words are numbered from 0 within a stream.
- R3: The compression flag is set when bit 1 of word 229 is zero.
- R4: The ratio code is 0 = x1, 1 = x2, 2 = x4, 3 = x8. With neither flag set it is 0 at both widths.
- R5: `wide_i` is sampled on the beat that carries word 229, where 1 means 32-bit and 0 means 16-bit. At 16-bit width, compressed gives code 2 and encrypted-only gives code 1. At 32-bit width each of these is one code higher.
- R6: `done_o` is high for exactly the one cycle after word 229 is accepted. In that same cycle all result outputs take their new values, and they hold those values until the next done. After reset all results are 0.
- R7: If the last beat is accepted before word 229 (fewer than 230 words), `err_o` is high for one cycle and the results do not change.
- R8: The security code is taken from the low halfword of word 0, or failing that, from the low halfword of word 1. Code 1 means a match with `MAGIC_CLR`, 2 means a match with `MAGIC_ENC`, and 0 means invalid.
- R9: Halfwords are numbered low half first within each word. The section code is found by checking the halfword one after the magic and then the halfword two after it. Code 1 means `ID_PERI`, 2 means `ID_CORE`, and 0 means unknown. Code 0 is also used when the magic is invalid.
- R10: Beats after word 229 up to the last beat do not affect the results and raise no done. The beat after a last beat starts a new header at word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wide_i | input | 1 | Configuration width select, 1 = 32-bit |
| in_valid_i | input | 1 | Stream beat valid |
| in_data_i | input | 32 | Stream beat data |
| in_last_i | input | 1 | Final beat of the stream |
| in_ready_o | output | 1 | Ready returned to the source |
| dn_ready_i | input | 1 | Ready from the downstream consumer |
| done_o | output | 1 | Header results updated (one cycle) |
| err_o | output | 1 | Stream ended before the header was complete (one cycle) |
| ratio_o | output | 2 | Clock-to-data ratio code |
| wide_o | output | 1 | Width captured with the results |
| encrypt_o | output | 1 | Encryption flag |
| compress_o | output | 1 | Compression flag |
| sec_o | output | 2 | Security magic class |
| sect_o | output | 2 | Section type |

## Verification
The hardest case to reach from the ports is a secondary magic match where the section halfword sits two positions away. Reaching it needs the first low halfword to miss, the second to hit, and the adjacent halfword to miss as well. The stimulus builds the first three words by hand for each stream to land in that case and its neighbours. Further streams cover these boundary lengths: exactly 230 words, one word short, and long tails after word 229. Periodic ready drops are added so that stalled beats are not counted.

// File: rtl/bs_hdr_pkg.sv
package bs_hdr_pkg;
  typedef enum logic [1:0] {SEC_NONE = 2'd0, SEC_CLEAR = 2'd1, SEC_CIPHER = 2'd2} sec_e;
  typedef enum logic [1:0] {SECT_UNK = 2'd0, SECT_PERI = 2'd1, SECT_CORE = 2'd2} sect_e;
endpackage

// File: rtl/bs_hdr_count.sv
module bs_hdr_count #(
  parameter int unsigned LIMIT = 230,
  parameter int unsigned CW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          beat_i,
  input  logic          last_i,
  output logic [CW-1:0] idx_o
);
  localparam logic [CW-1:0] SAT = CW'(LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          idx_o <= '0;
    else if (beat_i) begin
      if (last_i)         idx_o <= '0;
      else if (idx_o != SAT) idx_o <= idx_o + 1'b1;
    end
  end
endmodule

// File: rtl/bs_hdr_magic.sv
module bs_hdr_magic
  import bs_hdr_pkg::*;
#(
  parameter int unsigned   NW        = 3,
  parameter int unsigned   DW        = 32,
  parameter logic [15:0]   MAGIC_CLR = 16'h62f1,
  parameter logic [15:0]   MAGIC_ENC = 16'h62f2,
  parameter logic [15:0]   ID_PERI   = 16'h0a11,
  parameter logic [15:0]   ID_CORE   = 16'h0c22
) (
  input  logic [NW*DW-1:0] hdr_i,
  output sec_e             sec_o,
  output sect_e            sect_o
);
  localparam int unsigned HW  = DW / 2;
  localparam int unsigned NHW = 2 * NW;

  logic [HW-1:0] hw [NHW];
  for (genvar j = 0; j < NHW; j++) begin : g_hw
    assign hw[j] = hdr_i[j*HW +: HW];
  end

  function automatic sect_e kind(input logic [HW-1:0] h);
    if (h == ID_PERI)      return SECT_PERI;
    else if (h == ID_CORE) return SECT_CORE;
    else                   return SECT_UNK;
  endfunction

  logic [2:0] base;
  logic       hit;
  sect_e      near, far;

  always_comb begin
    hit  = 1'b1;
    base = 3'd0;
    sec_o = SEC_NONE;
    if      (hw[0] == MAGIC_CLR) sec_o = SEC_CLEAR;
    else if (hw[0] == MAGIC_ENC) sec_o = SEC_CIPHER;
    else if (hw[2] == MAGIC_CLR) begin sec_o = SEC_CLEAR;  base = 3'd2; end
    else if (hw[2] == MAGIC_ENC) begin sec_o = SEC_CIPHER; base = 3'd2; end
    else hit = 1'b0;
    near = kind(hw[base + 3'd1]);
    far  = kind(hw[base + 3'd2]);
    if (!hit)                sect_o = SECT_UNK;
    else if (near != SECT_UNK) sect_o = near;
    else                     sect_o = far;
  end
endmodule

// File: rtl/bs_hdr_ratio.sv
module bs_hdr_ratio (
  input  logic       enc_i,
  input  logic       cmp_i,
  input  logic       wide_i,
  output logic [1:0] ratio_o
);
  // 0=x1 1=x2 2=x4 3=x8; 32-bit width doubles any non-unity ratio
  always_comb begin
    if (!enc_i && !cmp_i) ratio_o = 2'd0;
    else                  ratio_o = (cmp_i ? 2'd2 : 2'd1) + {1'b0, wide_i};
  end
endmodule

// File: rtl/bs_hdr_probe.sv
module bs_hdr_probe
  import bs_hdr_pkg::*;
#(
  parameter int unsigned DW        = 32,
  parameter int unsigned ENC_IDX   = 69,
  parameter int unsigned CMP_IDX   = 229,
  parameter int unsigned ENC_LSB   = 2,
  parameter int unsigned CMP_BIT   = 1,
  parameter logic [15:0] MAGIC_CLR = 16'h62f1,
  parameter logic [15:0] MAGIC_ENC = 16'h62f2,
  parameter logic [15:0] ID_PERI   = 16'h0a11,
  parameter logic [15:0] ID_CORE   = 16'h0c22
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wide_i,
  input  logic          in_valid_i,
  input  logic [DW-1:0] in_data_i,
  input  logic          in_last_i,
  output logic          in_ready_o,
  input  logic          dn_ready_i,
  output logic          done_o,
  output logic          err_o,
  output logic [1:0]    ratio_o,
  output logic          wide_o,
  output logic          encrypt_o,
  output logic          compress_o,
  output logic [1:0]    sec_o,
  output logic [1:0]    sect_o
);
  localparam int unsigned HDR_WORDS = CMP_IDX + 1;
  localparam int unsigned CW        = $clog2(HDR_WORDS + 1);
  localparam int unsigned NW        = 3;

  logic          beat;
  logic [CW-1:0] idx;
  logic [NW*DW-1:0] hdr_q;
  logic          enc_q;
  logic          cmp_w;
  logic [1:0]    ratio_w;
  sec_e          sec_w;
  sect_e         sect_w;

  assign in_ready_o = dn_ready_i;
  assign beat       = in_valid_i & dn_ready_i;

  bs_hdr_count #(.LIMIT(HDR_WORDS), .CW(CW)) u_count (
    .clk_i (clk_i), .rst_ni(rst_ni), .beat_i(beat), .last_i(in_last_i), .idx_o(idx)
  );

  for (genvar k = 0; k < NW; k++) begin : g_hdr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        hdr_q[k*DW +: DW] <= '0;
      else if (beat && idx == CW'(k))     hdr_q[k*DW +: DW] <= in_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          enc_q <= 1'b0;
    else if (beat && idx == CW'(ENC_IDX)) enc_q <= |in_data_i[ENC_LSB +: 2];
  end

  assign cmp_w = ~in_data_i[CMP_BIT];

  bs_hdr_ratio u_ratio (.enc_i(enc_q), .cmp_i(cmp_w), .wide_i(wide_i), .ratio_o(ratio_w));

  bs_hdr_magic #(
    .NW(NW), .DW(DW), .MAGIC_CLR(MAGIC_CLR), .MAGIC_ENC(MAGIC_ENC),
    .ID_PERI(ID_PERI), .ID_CORE(ID_CORE)
  ) u_magic (.hdr_i(hdr_q), .sec_o(sec_w), .sect_o(sect_w));

  logic fin;
  assign fin = beat && idx == CW'(CMP_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0; err_o <= 1'b0; ratio_o <= '0; wide_o <= 1'b0;
      encrypt_o <= 1'b0; compress_o <= 1'b0; sec_o <= '0; sect_o <= '0;
    end else begin
      done_o <= fin;
      err_o  <= beat && in_last_i && (idx < CW'(CMP_IDX));
      if (fin) begin
        ratio_o    <= ratio_w;
        wide_o     <= wide_i;
        encrypt_o  <= enc_q;
        compress_o <= cmp_w;
        sec_o      <= sec_w;
        sect_o     <= sect_w;
      end
    end
  end
endmodule

// File: rtl/bs_hdr_probe_chk.sv
module bs_hdr_probe_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       done_o,
  input logic       err_o,
  input logic [1:0] ratio_o,
  input logic       wide_o,
  input logic       encrypt_o,
  input logic       compress_o,
  input logic [1:0] sec_o,
  input logic [1:0] sect_o
);
  assert_done_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(ratio_o) && $stable(wide_o) && $stable(encrypt_o) &&
                 $stable(compress_o) && $stable(sec_o) && $stable(sect_o)));

  assert_no_change_on_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ($stable(ratio_o) && $stable(sec_o) && $stable(sect_o)));

  assert_plain_x1_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !encrypt_o && !compress_o) |-> ratio_o == 2'd0);

  assert_narrow_cap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !wide_o) |-> ratio_o != 2'd3);

  assert_cmp_ratio_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && compress_o) |-> ratio_o == {1'b1, wide_o});

  assert_sect_needs_magic_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_o == 2'd0) |-> sect_o == 2'd0);
endmodule

bind bs_hdr_probe bs_hdr_probe_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .done_o(done_o), .err_o(err_o),
  .ratio_o(ratio_o), .wide_o(wide_o), .encrypt_o(encrypt_o),
  .compress_o(compress_o), .sec_o(sec_o), .sect_o(sect_o)
);

// File: tb/bs_hdr_probe_test.sv
module bs_hdr_probe_test;
  localparam logic [15:0] MC = 16'h62f1, ME = 16'h62f2, IP = 16'h0a11, IC = 16'h0c22;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wide = 1'b0, in_valid = 1'b0, in_last = 1'b0, dn_ready = 1'b1;
  logic [31:0] in_data = '0;
  logic in_ready, done, err, wide_q, enc, cmp;
  logic [1:0] ratio, sec, sect;

  always #5 clk = ~clk;

  bs_hdr_probe #(.MAGIC_CLR(MC), .MAGIC_ENC(ME), .ID_PERI(IP), .ID_CORE(IC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wide_i(wide), .in_valid_i(in_valid),
    .in_data_i(in_data), .in_last_i(in_last), .in_ready_o(in_ready),
    .dn_ready_i(dn_ready), .done_o(done), .err_o(err), .ratio_o(ratio),
    .wide_o(wide_q), .encrypt_o(enc), .compress_o(cmp), .sec_o(sec), .sect_o(sect)
  );

  int checks = 0, errors = 0, dones = 0, errs = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  int m_idx = 0;
  logic [31:0] m_w [3];
  bit m_enc = 0;
  bit e_done = 0, e_err = 0, e_wide = 0, e_enc = 0, e_cmp = 0;
  int e_ratio = 0, e_sec = 0, e_sect = 0;

  function automatic logic [15:0] half(input int j);
    return m_w[j / 2][16 * (j % 2) +: 16];
  endfunction

  function automatic int sect_of(input logic [15:0] h);
    return (h == IP) ? 1 : (h == IC) ? 2 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_idx = 0; m_enc = 0; e_done = 0; e_err = 0; e_wide = 0; e_enc = 0; e_cmp = 0;
      e_ratio = 0; e_sec = 0; e_sect = 0;
    end else begin
      e_done = 0; e_err = 0;
      if (in_valid && dn_ready) begin
        if (m_idx < 3) m_w[m_idx] = in_data;
        if (m_idx == 69) m_enc = (in_data[3:2] != 2'b00);
        if (m_idx == 229) begin
          int mp;
          e_done = 1; e_enc = m_enc; e_cmp = !in_data[1]; e_wide = wide;
          if (!e_enc && !e_cmp) e_ratio = 0;
          else if (e_cmp)       e_ratio = wide ? 3 : 2;
          else                  e_ratio = wide ? 2 : 1;
          mp = -1; e_sec = 0;
          for (int p = 0; p <= 2; p += 2)
            if (mp < 0 && (half(p) == MC || half(p) == ME)) begin
              mp = p; e_sec = (half(p) == MC) ? 1 : 2;
            end
          e_sect = 0;
          if (mp >= 0) begin
            e_sect = sect_of(half(mp + 1));
            if (e_sect == 0) e_sect = sect_of(half(mp + 2));
          end
        end
        if (in_last) begin
          if (m_idx < 229) e_err = 1;
          m_idx = 0;
        end else if (m_idx < 230) m_idx++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(in_ready == dn_ready, "R1 ready", in_ready, dn_ready);
      chk(done == e_done, "R6 done", done, e_done);
      chk(err == e_err, "R7 err", err, e_err);
      chk(ratio == e_ratio[1:0], "R5 ratio", ratio, e_ratio);
      chk(wide_q == e_wide, "R5 width", wide_q, e_wide);
      chk(enc == e_enc, "R2 encrypt", enc, e_enc);
      chk(cmp == e_cmp, "R3 compress", cmp, e_cmp);
      chk(sec == e_sec[1:0], "R8 security", sec, e_sec);
      chk(sect == e_sect[1:0], "R9 section", sect, e_sect);
      if (done) dones++;
      if (err) errs++;
    end
  end

  task automatic run(input int n, input logic [1:0] e2, input bit cbit,
                     input logic [31:0] w0, w1, w2, input bit w, input bit stall);
    int d0 = dones, r0 = errs;
    @(negedge clk); wide = w;
    for (int i = 0; i < n; i++) begin
      logic [31:0] d;
      d = 32'ha5000000 ^ (i * 32'h00010203);
      if (i == 0) d = w0;
      if (i == 1) d = w1;
      if (i == 2) d = w2;
      if (i == 69) d[3:2] = e2;
      if (i == 229) d[1] = cbit;
      if (i > 0) @(negedge clk);
      in_valid = 1; in_data = d; in_last = (i == n - 1);
      dn_ready = !(stall && (i % 4 == 1));
      if (!dn_ready) begin @(negedge clk); dn_ready = 1; end
    end
    @(negedge clk); in_valid = 0; in_last = 0;
    repeat (2) @(negedge clk);
    chk(dones - d0 == (n >= 230 ? 1 : 0), "R10 done count", dones - d0, n >= 230);
    chk(errs - r0 == (n < 230 ? 1 : 0), "R7 err count", errs - r0, n < 230);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ratio == 0 && sec == 0 && sect == 0 && !done && !err, "R6 reset", {ratio, sec, sect}, 0);
    rst_n = 1;
    @(negedge clk);
    // plain, 32-bit, magic at hw0 with peripheral next
    run(230, 2'b00, 1'b1, {IP, MC}, 32'h0, 32'h0, 1'b1, 1'b0);
    chk(ratio == 2'd0, "R4 unity ratio", ratio, 0);
    chk(sec == 2'd1 && sect == 2'd1, "R8 R9 primary", {sec, sect}, 4'b0101);
    // encrypted-only, 16-bit, magic in word1 low, core two after
    run(232, 2'b01, 1'b1, 32'h0, {16'h0, ME}, {16'h0, IC}, 1'b0, 1'b1);
    chk(ratio == 2'd1 && sec == 2'd2 && sect == 2'd2, "R5 R9 secondary", {ratio, sec, sect}, 6'b011010);
    run(230, 2'b10, 1'b1, {IC, ME}, 32'h0, 32'h0, 1'b1, 1'b0);
    chk(ratio == 2'd2, "R5 enc wide", ratio, 2);
    run(240, 2'b00, 1'b0, {16'h0, MC}, IC, 32'h0, 1'b0, 1'b0);
    chk(ratio == 2'd2 && sect == 2'd2, "R5 cmp narrow", {ratio, sect}, 4'b1010);
    run(230, 2'b00, 1'b0, {16'h0, MC}, 32'h0, 32'h0, 1'b1, 1'b1);
    chk(ratio == 2'd3 && sect == 2'd0, "R5 R9 cmp wide unknown", {ratio, sect}, 4'b1100);
    run(231, 2'b11, 1'b0, 32'h0, 32'h0, 32'h0, 1'b1, 1'b0);
    chk(ratio == 2'd3 && sec == 2'd0 && sect == 2'd0, "R8 invalid", {ratio, sec, sect}, 6'b110000);
    run(230, 2'b11, 1'b0, {IP, MC}, 32'h0, 32'h0, 1'b0, 1'b0);
    // short streams keep results
    run(229, 2'b00, 1'b1, {IC, ME}, 32'h0, 32'h0, 1'b1, 1'b0);
    chk(ratio == 2'd2 && sec == 2'd1, "R7 held", {ratio, sec}, 4'b1001);
    run(1, 2'b00, 1'b1, 32'h0, 32'h0, 32'h0, 1'b1, 1'b0);
    run(100, 2'b00, 1'b1, 32'h0, 32'h0, 32'h0, 1'b0, 1'b1);
    // long tail ignored, then new header
    run(300, 2'b01, 1'b1, {16'h0, MC}, {16'h0, IP}, 32'h0, 1'b1, 1'b1);
    chk(ratio == 2'd2 && sect == 2'd1, "R10 tail ignored", {ratio, sect}, 4'b1001);
    run(230, 2'b00, 1'b1, 32'h0, {IP, ME}, 32'h0, 1'b0, 1'b0);
    chk(ratio == 2'd0 && sec == 2'd2 && sect == 2'd1, "R10 rearm", {ratio, sec, sect}, 6'b001001);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule